// File: doc/BRIEF.md
# Machine-Cycle Sampled Reset Controller

This block turns the raw, active-high reset pin of an 8-bit microcontroller into the core's internal reset. It runs from the oscillator clock alone. A free-running sequencer divides every machine cycle into six states of two phases each, twelve oscillator clocks in all, and brings the current state and phase out so the rest of the core can time itself from them.

The raw pin first passes through a two-flop conditioning stage, standing in for a hysteresis input buffer. The conditioned level is looked at in one slot of each machine cycle only: the second phase of the fifth state. Internal reset is raised once two samples in a row have seen the pin high. It is dropped at the first sample that sees the pin low. A pin held high for 24 oscillator clocks or more therefore always gives a reset, whatever its phase against the sequencer. A glitch that only one sample sees is ignored.

While reset is active, the block gives the program-counter load strobe once in each machine cycle, so that the counter is held at address 0000h and fetching restarts there when reset is released. The pin and the strobe are plain level signals with no handshake.

Top module: `mcu_reset_sampler`

## Requirements
- R1: `mc_state` counts 0 to 5 and wraps, meaning states one to six. `mc_phase` is 0 for the first phase and 1 for the second. Every state lasts two clocks, so a machine cycle is 12 clocks. After power-up both start at 0.
- R2: The pin reaches the sampler through two flip-flops. If the pin falls at the falling clock edge that opens state 4, phase 0, the sample taken at the end of that machine cycle's state 4, phase 1 slot still sees it high.
- R3: `core_rst` changes only on the clock edge that ends a state 4, phase 1 slot.
- R4: `core_rst` rises at the slot edge where the conditioned pin is high and the sample from the previous machine cycle was also high. After power-up `core_rst` is 0.
- R5: A high pin level that only one sample slot sees causes no reset.
- R6: `core_rst` falls at the first slot edge where the conditioned pin is low.
- R7: `pc_load_zero` is 1 for exactly the single clock of state 5, phase 0 in each machine cycle whose preceding sample left `core_rst` at 1. It is 0 in every other clock.
- R8: `pc_load_zero` is never 1 while `core_rst` is 0.
- R9: A pin held high for 24 consecutive clocks produces a reset for every alignment against the machine cycle.

Where `pc_load_zero` is 1, the program counter is loaded with 0000h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_osc | input | 1 | Oscillator clock |
| rst_pin_raw | input | 1 | Raw external reset pin, active high, asynchronous |
| core_rst | output | 1 | Internal reset for the core, active high |
| pc_load_zero | output | 1 | One-clock strobe that loads the program counter with 0000h during reset |
| mc_state | output | 3 | Current state in the machine cycle, 0..5 |
| mc_phase | output | 1 | Current phase in the state, 0 or 1 |

## Verification
A directed pulse twelve clocks wide, started at the beginning of a machine cycle, is seen by exactly one sample slot. It shows that one high sample is not enough for a reset. Twenty-four-clock pulses, started at each of the twelve offsets into the machine cycle, show that this minimum width always resets, whichever slot it straddles. A pin drop timed one clock before the slot separates the two-flop conditioning stage from a direct sample, because the reset must then last one more machine cycle. Random high and low runs of 1 to 40 clocks are compared clock by clock against a reference model in the bench, for both assertion and release of reset and for the strobe.

// File: rtl/mcu_rst_pkg.sv
package mcu_rst_pkg;
  // Default machine-cycle shape and sampling point
  localparam int unsigned STATES_PER_CYCLE = 6;
  localparam int unsigned PHASES_PER_STATE = 2;
  localparam int unsigned SAMPLE_STATE_IDX = 4;  // fifth state
  localparam int unsigned SAMPLE_PHASE_IDX = 1;  // second phase
  localparam int unsigned SYNC_DEPTH       = 2;
  localparam int unsigned HIGH_SAMPLES_REQ = 2;

  function automatic int unsigned width_of(input int unsigned n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction
endpackage

// File: rtl/mcu_rst_cycle_seq.sv
module mcu_rst_cycle_seq #(
  parameter int unsigned STATES = mcu_rst_pkg::STATES_PER_CYCLE,
  parameter int unsigned PHASES = mcu_rst_pkg::PHASES_PER_STATE,
  localparam int unsigned SW = mcu_rst_pkg::width_of(STATES),
  localparam int unsigned PW = mcu_rst_pkg::width_of(PHASES)
) (
  input  logic          clk,
  output logic [SW-1:0] state_o,
  output logic [PW-1:0] phase_o
);
  localparam logic [SW-1:0] LAST_ST = SW'(STATES - 1);
  localparam logic [PW-1:0] LAST_PH = PW'(PHASES - 1);

  logic [SW-1:0] st_q = '0;
  logic [PW-1:0] ph_q = '0;
  logic          live_q = 1'b0;

  always_ff @(posedge clk) begin
    live_q <= 1'b1;
    if (ph_q == LAST_PH) begin
      ph_q <= '0;
      st_q <= (st_q == LAST_ST) ? '0 : st_q + SW'(1);
    end else begin
      ph_q <= ph_q + PW'(1);
    end
  end

  assign state_o = st_q;
  assign phase_o = ph_q;

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!live_q)
    (ph_q != LAST_PH) |=> $stable(st_q)); // R1
  AST_STATE_WRAP: assert property (@(posedge clk) disable iff (!live_q)
    (ph_q == LAST_PH && st_q == LAST_ST) |=> (st_q == '0 && ph_q == '0)); // R1
endmodule

// File: rtl/mcu_rst_pin_sync.sv
module mcu_rst_pin_sync #(
  parameter int unsigned DEPTH = mcu_rst_pkg::SYNC_DEPTH
) (
  input  logic clk,
  input  logic pin_i,
  output logic lvl_o
);
  logic [DEPTH-1:0] sh_q = '0;

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) sh_q <= pin_i;
    end else begin : g_chain
      always_ff @(posedge clk) sh_q <= {sh_q[DEPTH-2:0], pin_i};
    end
  endgenerate

  assign lvl_o = sh_q[DEPTH-1];
endmodule

// File: rtl/mcu_rst_sampler.sv
module mcu_rst_sampler #(
  parameter int unsigned NEED = mcu_rst_pkg::HIGH_SAMPLES_REQ
) (
  input  logic clk,
  input  logic lvl_i,
  input  logic slot_i,
  output logic rst_o,
  output logic pcz_o
);
  logic [NEED-1:0] hist_q = '0;
  logic [NEED-1:0] hist_nx;
  logic            rst_q = 1'b0;
  logic            rst_nx;
  logic            stb_q = 1'b0;
  logic            live_q = 1'b0;

  assign hist_nx = {hist_q[NEED-2:0], lvl_i};

  always_comb begin
    rst_nx = rst_q;
    if (slot_i) begin
      if (&hist_nx)    rst_nx = 1'b1;
      else if (!lvl_i) rst_nx = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    live_q <= 1'b1;
    if (slot_i) hist_q <= hist_nx;
    rst_q <= rst_nx;
    stb_q <= slot_i && rst_nx;
  end

  assign rst_o = rst_q;
  assign pcz_o = stb_q;

  AST_RST_AT_SLOT: assert property (@(posedge clk) disable iff (!live_q)
    !$stable(rst_q) |-> $past(slot_i)); // R3
  AST_RISE_TWO_HIGH: assert property (@(posedge clk) disable iff (!live_q)
    $rose(rst_q) |-> (&hist_q)); // R4
  AST_FALL_ON_LOW: assert property (@(posedge clk) disable iff (!live_q)
    $fell(rst_q) |-> !hist_q[0]); // R6
  AST_STROBE_AFTER_SLOT: assert property (@(posedge clk) disable iff (!live_q)
    stb_q |-> $past(slot_i)); // R7
  AST_STROBE_IN_RST: assert property (@(posedge clk) disable iff (!live_q)
    stb_q |-> rst_q); // R8
endmodule

// File: rtl/mcu_reset_sampler.sv
module mcu_reset_sampler #(
  parameter int unsigned STATES       = mcu_rst_pkg::STATES_PER_CYCLE,
  parameter int unsigned PHASES       = mcu_rst_pkg::PHASES_PER_STATE,
  parameter int unsigned SAMPLE_STATE = mcu_rst_pkg::SAMPLE_STATE_IDX,
  parameter int unsigned SAMPLE_PHASE = mcu_rst_pkg::SAMPLE_PHASE_IDX,
  parameter int unsigned SYNC_STAGES  = mcu_rst_pkg::SYNC_DEPTH,
  parameter int unsigned HIGH_SAMPLES = mcu_rst_pkg::HIGH_SAMPLES_REQ,
  localparam int unsigned SW = mcu_rst_pkg::width_of(STATES),
  localparam int unsigned PW = mcu_rst_pkg::width_of(PHASES)
) (
  input  logic          clk_osc,
  input  logic          rst_pin_raw,
  output logic          core_rst,
  output logic          pc_load_zero,
  output logic [SW-1:0] mc_state,
  output logic [PW-1:0] mc_phase
);
  logic pin_lvl;
  logic sample_slot;

  mcu_rst_cycle_seq #(.STATES(STATES), .PHASES(PHASES)) u_seq (
    .clk     (clk_osc),
    .state_o (mc_state),
    .phase_o (mc_phase)
  );

  mcu_rst_pin_sync #(.DEPTH(SYNC_STAGES)) u_sync (
    .clk   (clk_osc),
    .pin_i (rst_pin_raw),
    .lvl_o (pin_lvl)
  );

  assign sample_slot = (mc_state == SW'(SAMPLE_STATE)) && (mc_phase == PW'(SAMPLE_PHASE));

  mcu_rst_sampler #(.NEED(HIGH_SAMPLES)) u_samp (
    .clk    (clk_osc),
    .lvl_i  (pin_lvl),
    .slot_i (sample_slot),
    .rst_o  (core_rst),
    .pcz_o  (pc_load_zero)
  );
endmodule

// File: tb/tb_mcu_reset_sampler.sv
module tb_mcu_reset_sampler;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       pin = 1'b0;
  logic       core_rst, pc_load_zero;
  logic [2:0] mc_state;
  logic [0:0] mc_phase;

  int errors = 0;
  int checks = 0;
  bit cmp_en = 1'b0;
  bit seen_rst = 1'b0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mcu_reset_sampler dut (
    .clk_osc(clk), .rst_pin_raw(pin), .core_rst(core_rst),
    .pc_load_zero(pc_load_zero), .mc_state(mc_state), .mc_phase(mc_phase)
  );

  // Reference model built from the requirements
  int m_cnt = 0;
  bit m_s1 = 0, m_s2 = 0, m_prev = 0, m_rst = 0, m_stb = 0;
  bit slot_b, nr_b;

  always @(posedge clk) begin
    slot_b = (m_cnt == 9);
    nr_b   = m_rst;
    if (slot_b) begin
      if (m_s2 && m_prev) nr_b = 1'b1;
      else if (!m_s2)     nr_b = 1'b0;
      m_prev <= m_s2;
    end
    m_rst <= nr_b;
    m_stb <= slot_b && nr_b;
    m_s2  <= m_s1;
    m_s1  <= pin;
    m_cnt <= (m_cnt == 11) ? 0 : m_cnt + 1;
  end

  task automatic chk(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic int exp_state(input int c); return c / 2; endfunction
  function automatic int exp_phase(input int c); return c % 2; endfunction

  always @(negedge clk) begin
    if (core_rst) seen_rst = 1'b1;
    if (cmp_en) begin
      chk("R1 state", int'(mc_state), exp_state(m_cnt));
      chk("R1 phase", int'(mc_phase), exp_phase(m_cnt));
      if (m_rst) chk("R4 core_rst", int'(core_rst), 1);
      else       chk("R6 core_rst", int'(core_rst), 0);
      chk("R7 pc_load_zero", int'(pc_load_zero), int'(m_stb));
      if (pc_load_zero && !core_rst) chk("R8 strobe outside reset", 1, 0);
    end
  end

  task automatic align(input int st, input int ph);
    do @(negedge clk); while (!(int'(mc_state) == st && int'(mc_phase) == ph));
  endtask

  task automatic hold(input bit v, input int n);
    pin = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'd20240611);
    @(negedge clk);
    chk("R4 reset state core_rst", int'(core_rst), 0);
    chk("R1 reset state mc_state", int'(mc_state), 0);
    chk("R7 reset state pc_load_zero", int'(pc_load_zero), 0);
    cmp_en = 1'b1;

    // R5: 12-clock pulse from the start of a machine cycle hits one slot only
    align(0, 0);
    seen_rst = 1'b0;
    hold(1'b1, 12);
    hold(1'b0, 40);
    chk("R5 single-sample pulse", int'(seen_rst), 0);

    // R9: 24-clock pulse at every alignment resets
    for (int off = 0; off < 12; off++) begin
      align(0, 0);
      repeat (off) @(negedge clk);
      seen_rst = 1'b0;
      hold(1'b1, 24);
      hold(1'b0, 40);
      chk("R9 minimum-width pulse resets", int'(seen_rst), 1);
      chk("R6 released after low", int'(core_rst), 0);
    end

    // R2: drop just before the slot; conditioning delay keeps reset one more cycle
    hold(1'b1, 40);
    chk("R4 long high asserts", int'(core_rst), 1);
    align(4, 0);
    pin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk("R2 synchronized sample still high", int'(core_rst), 1);
    chk("R7 strobe in state 5 phase 0", int'(pc_load_zero), 1);
    repeat (12) @(negedge clk);
    chk("R6 drop on first low sample", int'(core_rst), 0);
    chk("R7 no strobe after release", int'(pc_load_zero), 0);

    // Random runs against the model (R3, R4, R6, R7)
    for (int b = 0; b < 60; b++) begin
      hold(1'b1, 1 + int'($urandom_range(39)));
      hold(1'b0, 1 + int'($urandom_range(39)));
    end
    hold(1'b0, 30);
    chk("R3 idle after random runs", int'(core_rst), 0);
    finish_run();
  end
endmodule